// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a global history register that holds the outcomes of the most recent conditional branches. It also keeps a table of 2-bit saturating counters with 2^HIST_LEN entries. A table slot is picked by XORing the word-aligned fetch PC with that history. The front end presents a fetch on the lookup port and gets the predicted direction back in the same cycle, combinationally. The lookup reads state only.

The resolved outcome arrives on the update port, normally in the same cycle as the prediction. The history and the selected counter are then trained with the true outcome. Nothing is updated speculatively, so no history checkpoint or repair is needed. In that update cycle the block raises a mispredict flag when the counter disagreed with the outcome, and the front end uses this flag to hold fetch until the branch resolves. Two saturating statistics counters record how many conditional branches were trained and how many of them were mispredicted, so accuracy can be measured.

Non-conditional control flow must not be presented on the update port. It is treated as correctly predicted and never touches the predictor. HIST_LEN must be at least 2; 4, 8 (the default) and 12 are the intended settings.

Top module: `gshare_predictor`

## Requirements
- R1: After reset every table counter holds binary 10, the history register is zero and both statistics counters are zero, so the first lookup of any PC predicts taken.
- R2: The table index for a PC is PC bits [ALIGN_BITS+HIST_LEN-1:ALIGN_BITS] XOR the history register (ALIGN_BITS defaults to 2).
- R3: pred_valid is high exactly when lk_valid and lk_is_cond are both high; pred_taken then equals bit 1 (the MSB) of the indexed counter (1 = taken), and is 0 whenever pred_valid is low.
- R4: On an update the indexed counter increments when upd_taken is 1 and decrements when it is 0, saturating at 11 and 00.
- R5: On an update the history register shifts left by one, upd_taken enters bit 0, and the result is truncated to HIST_LEN bits; the register is visible on ghist.
- R6: In a cycle with upd_valid low, no counter, the history and the statistics counters all keep their values, whatever the lookup port carries.
- R7: mispredict is high in a cycle exactly when upd_valid is high and the MSB of the counter at the update index, as it stood before that cycle's write, differs from upd_taken.
- R8: branch_count increments on every update and miss_count on every update that raises mispredict; both hold at all ones instead of wrapping.
- R9: A lookup and an update in the same cycle, even at the same index, both see the state from before that cycle; the update becomes visible to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_pc | input | PC_W | Fetch PC of the lookup |
| lk_is_cond | input | 1 | Lookup instruction is a conditional branch |
| pred_valid | output | 1 | Prediction is meaningful this cycle |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved conditional branch trains the predictor |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| mispredict | output | 1 | Counter disagreed with the resolved direction; stall fetch |
| ghist | output | HIST_LEN | Current global history register |
| branch_count | output | CNT_W | Trained conditional branches, saturating |
| miss_count | output | CNT_W | Mispredicted conditional branches, saturating |

## Verification
Lookup and training can fall in the same cycle, and the risky case is when both target the same table slot. Then the lookup must return the counter from before the write, and the mispredict flag must be judged on that same old value. The bench provokes this by driving one PC on both ports for long runs. This keeps hitting one slot while the history fills and then stays fixed. It also uses a random mix over a small set of PCs so that the XOR hash makes different PCs collide. A behavioural reference model reads its table before it writes, and it is compared against every output on every clock.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_WEAK_TAKEN = 2'b10;
    localparam ctr2_t CTR_MAX        = 2'b11;
    localparam ctr2_t CTR_MIN        = 2'b00;

    function automatic ctr2_t ctr_train(input ctr2_t cur, input logic taken);
        ctr2_t nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_MAX) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_MIN) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/gsp_hash.sv
module gsp_hash #(
    parameter int HIST_LEN   = 8,
    parameter int PC_W       = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic [PC_W-1:0]     pc,
    input  logic [HIST_LEN-1:0] hist,
    output logic [HIST_LEN-1:0] idx
);
    always_comb begin
        idx = pc[ALIGN_BITS +: HIST_LEN] ^ hist;
    end
endmodule

// File: rtl/gsp_pht.sv
module gsp_pht
    import gsp_pkg::*;
#(
    parameter int HIST_LEN = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HIST_LEN-1:0] rd_a_idx,
    output ctr2_t               rd_a_val,
    input  logic [HIST_LEN-1:0] rd_b_idx,
    output ctr2_t               rd_b_val,
    input  logic                wr_en,
    input  logic [HIST_LEN-1:0] wr_idx,
    input  logic                wr_taken
);
    localparam int DEPTH = 1 << HIST_LEN;

    ctr2_t tbl_q [DEPTH];
    ctr2_t tbl_d [DEPTH];

    always_comb begin
        rd_a_val = tbl_q[rd_a_idx];
        rd_b_val = tbl_q[rd_b_idx];
    end

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx] = ctr_train(tbl_q[wr_idx], wr_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '{default: CTR_WEAK_TAKEN};
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // R4: a taken update steps a non-saturated counter up by one
    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && tbl_q[wr_idx] != CTR_MAX)
        |=> (tbl_q[$past(wr_idx)] == $past(tbl_q[wr_idx]) + 2'd1));

    // R4: saturation at the top
    a_r4_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && tbl_q[wr_idx] == CTR_MAX)
        |=> (tbl_q[$past(wr_idx)] == CTR_MAX));

    // R4: saturation at the bottom
    a_r4_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && tbl_q[wr_idx] == CTR_MIN)
        |=> (tbl_q[$past(wr_idx)] == CTR_MIN));

endmodule

// File: rtl/gsp_stats.sv
module gsp_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_branch,
    input  logic             inc_miss,
    output logic [CNT_W-1:0] branch_count,
    output logic [CNT_W-1:0] miss_count
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] branches;
        logic [CNT_W-1:0] misses;
    } stats_t;

    stats_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (inc_branch && st_q.branches != CNT_TOP) st_d.branches = st_q.branches + 1'b1;
        if (inc_miss && st_q.misses != CNT_TOP)     st_d.misses   = st_q.misses + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign branch_count = st_q.branches;
    assign miss_count   = st_q.misses;

    // R8: every training event advances the branch tally unless saturated
    a_r8_branch_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_branch && st_q.branches != CNT_TOP) |=> (st_q.branches == $past(st_q.branches) + 1'b1));

    // R8: misses can never outnumber trained branches
    a_r8_miss_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.misses <= st_q.branches);

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
    import gsp_pkg::*;
#(
    parameter int HIST_LEN   = 8,
    parameter int PC_W       = 32,
    parameter int ALIGN_BITS = 2,
    parameter int CNT_W      = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_valid,
    input  logic [PC_W-1:0]     lk_pc,
    input  logic                lk_is_cond,
    output logic                pred_valid,
    output logic                pred_taken,
    input  logic                upd_valid,
    input  logic [PC_W-1:0]     upd_pc,
    input  logic                upd_taken,
    output logic                mispredict,
    output logic [HIST_LEN-1:0] ghist,
    output logic [CNT_W-1:0]    branch_count,
    output logic [CNT_W-1:0]    miss_count
);
    typedef struct packed {
        logic [HIST_LEN-1:0] hist;
    } front_t;

    front_t fs_q, fs_d;

    logic [HIST_LEN-1:0] lk_idx, upd_idx;
    ctr2_t               lk_ctr, upd_ctr;
    logic                miss_now;

    gsp_hash #(.HIST_LEN(HIST_LEN), .PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS)) u_hash_lk (
        .pc(lk_pc), .hist(fs_q.hist), .idx(lk_idx)
    );

    gsp_hash #(.HIST_LEN(HIST_LEN), .PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS)) u_hash_upd (
        .pc(upd_pc), .hist(fs_q.hist), .idx(upd_idx)
    );

    gsp_pht #(.HIST_LEN(HIST_LEN)) u_pht (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(lk_idx),  .rd_a_val(lk_ctr),
        .rd_b_idx(upd_idx), .rd_b_val(upd_ctr),
        .wr_en(upd_valid), .wr_idx(upd_idx), .wr_taken(upd_taken)
    );

    gsp_stats #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst_n(rst_n),
        .inc_branch(upd_valid), .inc_miss(miss_now),
        .branch_count(branch_count), .miss_count(miss_count)
    );

    always_comb begin
        miss_now   = upd_valid && (upd_ctr[1] != upd_taken);
        pred_valid = lk_valid && lk_is_cond;
        pred_taken = pred_valid && lk_ctr[1];
        fs_d       = fs_q;
        if (upd_valid) begin
            fs_d.hist = {fs_q.hist[HIST_LEN-2:0], upd_taken};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign mispredict = miss_now;
    assign ghist      = fs_q.hist;

    // R3: no direction is reported without a conditional lookup
    a_r3_pred_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |-> !pred_taken);

    // R5: history shifts in the resolved outcome
    a_r5_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghist == {$past(ghist[HIST_LEN-2:0]), $past(upd_taken)}));

    // R6: idle update port leaves history and tallies alone
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(ghist) && $stable(branch_count) && $stable(miss_count)));

    // R7: a flagged miss implies a training event
    a_r7_miss_needs_update: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> upd_valid);

endmodule

// File: tb/sim_gshare_predictor.sv
module sim_gshare_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int H     = 8;
    localparam int PC_W  = 32;
    localparam int CNT_W = 16;
    localparam int DEPTH = 1 << H;
    localparam int MASK  = DEPTH - 1;
    localparam int CTOP  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0, lk_is_cond = 1'b0;
    logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
    logic upd_valid = 1'b0, upd_taken = 1'b0;
    logic pred_valid, pred_taken, mispredict;
    logic [H-1:0] ghist;
    logic [CNT_W-1:0] branch_count, miss_count;

    gshare_predictor #(.HIST_LEN(H), .PC_W(PC_W), .ALIGN_BITS(2), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_is_cond(lk_is_cond),
        .pred_valid(pred_valid), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .mispredict(mispredict), .ghist(ghist),
        .branch_count(branch_count), .miss_count(miss_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int m_pht [DEPTH];
    int m_hist;
    int m_br;
    int m_miss;

    task automatic check(input int act, input int exp, input string req, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int hidx(input logic [PC_W-1:0] pc);
        return ((int'(pc) >> 2) ^ m_hist) & MASK;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_pht[i] = 2;
        m_hist = 0; m_br = 0; m_miss = 0;
    endtask

    // one clock: drive at falling edge, compare, then advance the model
    task automatic step(input bit lv, input logic [PC_W-1:0] lpc, input bit lc,
                        input bit uv, input logic [PC_W-1:0] upc, input bit ut,
                        input string tag);
        int li, ui, ep, em;
        @(negedge clk);
        lk_valid = lv; lk_pc = lpc; lk_is_cond = lc;
        upd_valid = uv; upd_pc = upc; upd_taken = ut;
        #1;
        li = hidx(lpc);
        ui = hidx(upc);
        check(int'(ghist), m_hist, {"R5 ", tag}, "ghist");
        check(int'(branch_count), m_br, {"R8 ", tag}, "branch_count");
        check(int'(miss_count), m_miss, {"R8 ", tag}, "miss_count");
        check(int'(pred_valid), int'(lv && lc), {"R3 ", tag}, "pred_valid");
        ep = (lv && lc) ? int'(m_pht[li] >= 2) : 0;
        check(int'(pred_taken), ep, {"R2/R3 ", tag}, "pred_taken");
        em = uv ? int'((m_pht[ui] >= 2) != ut) : 0;
        check(int'(mispredict), em, {"R7 ", tag}, "mispredict");
        if (uv) begin
            if (m_br < CTOP) m_br++;
            if (em != 0 && m_miss < CTOP) m_miss++;
            if (ut) m_pht[ui] = (m_pht[ui] < 3) ? m_pht[ui] + 1 : 3;
            else    m_pht[ui] = (m_pht[ui] > 0) ? m_pht[ui] - 1 : 0;
            m_hist = ((m_hist << 1) | int'(ut)) & MASK;
        end
    endtask

    function automatic logic [PC_W-1:0] rpc();
        return PC_W'(($urandom % 16) << 2);
    endfunction

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(int'(ghist), 0, "R1", "ghist after reset");
        check(int'(branch_count), 0, "R1", "branch_count after reset");
        check(int'(miss_count), 0, "R1", "miss_count after reset");
        rst_n = 1'b1;
        // R1: any first lookup predicts weakly taken
        for (int i = 0; i < 8; i++) step(1, PC_W'(i*36), 1, 0, '0, 0, "R1 first-lookup");
        // R4: repeated taken at one PC saturates high, then not-taken saturates low
        for (int i = 0; i < 20; i++) step(1, 32'h40, 1, 1, 32'h40, 1, "R4/R9 sat-high");
        for (int i = 0; i < 20; i++) step(1, 32'h40, 1, 1, 32'h40, 0, "R4/R9 sat-low");
        for (int i = 0; i < 6; i++) step(1, 32'h40, 1, 1, 32'h40, 1, "R4/R9 climb");
        // R6: idle update port with busy lookup port
        for (int i = 0; i < 30; i++) step(1, rpc(), $urandom % 2, 0, rpc(), $urandom % 2, "R6 idle");
        // non-conditional lookups
        for (int i = 0; i < 20; i++) step(1, rpc(), 0, $urandom % 2, rpc(), $urandom % 2, "R3 noncond");
        // R9: same-PC lookup and update, random outcomes
        for (int i = 0; i < 300; i++) begin
            logic [PC_W-1:0] p = rpc();
            step(1, p, 1, 1, p, $urandom % 2, "R9 same-slot");
        end
        // biased pattern: loop-like branch taken 7 of 8
        for (int i = 0; i < 400; i++) step(1, 32'h80, 1, 1, 32'h80, (i % 8) != 7, "R2 loop");
        // general random mix
        for (int i = 0; i < 1500; i++)
            step($urandom % 2, rpc(), $urandom % 2, $urandom % 2, rpc(), $urandom % 2, "R2/R7 random");
        // reset again mid-run
        @(negedge clk);
        rst_n = 1'b0; upd_valid = 1'b0;
        @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        step(1, 32'h40, 1, 0, '0, 0, "R1 re-reset");
        step(0, '0, 0, 0, '0, 0, "R1 re-reset");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule